// File: doc/BRIEF.md
# Variable-Width Bit Extraction Buffer

This block sits between a host processor and a frame parser that consumes a packed serial parameter stream. The host pushes whole bytes; the parser pulls fields of 1, 3, 4, 5 or 6 bits, in the order the bits were written. All storage is one 128-bit shift register. A single counter holds how many of its bits are free. New bytes are placed, bit-reversed, just behind the stored data. Each extraction shifts the register toward its read end, so free space always sits on the write side.

The host sees two status flags, "empty" and "low". It also gets an interrupt request that fires when the fill level drops into the low region. The interrupt stays up until the host reads status, shown here by a one-cycle strobe. A field request that wants more bits than are stored is still served: the missing bits read as zero and an underrun marker accompanies the result.

Top module: `field_bitbuf`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the buffer. All 128 bits become free, `buf_empty` and `buf_low` read 1, and `irq` and `rd_valid` read 0.
- R2: Bits leave in the order they were written: the bits of each byte from bit 0 up to bit 7, then the bits of the next byte. A field is right-aligned on `rd_data`, with the first extracted bit in bit 0 and the unused upper bits zero.
- R3: `rd_width` carries the field width as a plain binary number. A request with a legal width removes that many bits from the stored data. It produces a one-cycle `rd_valid` pulse on the edge after the request, with the field on `rd_data` in that same cycle.
- R4: The width codes 0, 2 and 7 are ignored. They produce no `rd_valid` and leave the buffer contents unchanged.
- R5: A byte write succeeds only if, after any read in the same cycle, at least 8 bits are free. Otherwise the byte is dropped and the stored bits stay untouched.
- R6: If a request asks for more bits than are stored, it returns all remaining bits, fills the rest of the field with zeros, and raises `rd_underrun` together with `rd_valid`. The buffer is then empty.
- R7: `buf_empty` is 1 exactly when all 128 bits are free.
- R8: `buf_low` is 1 exactly when fewer than 64 bits are stored.
- R9: `irq` rises in the same cycle that `buf_low` rises, and stays high until a cycle with `stat_rd` high clears it. If a new rising edge of `buf_low` coincides with `stat_rd`, `irq` stays set.
- R10: When a read and a write arrive in the same cycle, the read takes effect first. A byte offered to a buffer with only 4 free bits is therefore accepted if the same cycle reads 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Byte write strobe from the host |
| wr_data | input | 8 | Byte to store |
| rd_req | input | 1 | Field request from the parser |
| rd_width | input | 3 | Requested field width in bits |
| stat_rd | input | 1 | Host status read; acknowledges the interrupt |
| rd_data | output | 6 | Extracted field, right-aligned |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` valid |
| rd_underrun | output | 1 | Field was short of stored bits |
| buf_empty | output | 1 | No bits stored |
| buf_low | output | 1 | Fewer than 64 bits stored |
| irq | output | 1 | Interrupt request for the low condition |

## Verification
The properties assume that `rst` is high during the first clock edge. They also assume that `wr_en`, `rd_req`, `rd_width` and `stat_rd` are always known values, since the illegal-width and reject properties branch on them. The bench changes every input only on falling edges, so each value is stable across the sampling edge. It starts every scenario with a reset cycle. It drives illegal width codes only on purpose and on their own, so the properties about ignored requests see exactly the condition they describe.

// File: rtl/field_bitbuf.sv
module field_bitbuf #(
  parameter int DEPTH   = 128,
  parameter int BYTE_W  = 8,
  parameter int FIELD_W = 6,
  parameter int WID_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic               rd_req,
  input  logic [WID_W-1:0]   rd_width,
  input  logic               stat_rd,
  output logic [FIELD_W-1:0] rd_data,
  output logic               rd_valid,
  output logic               rd_underrun,
  output logic               buf_empty,
  output logic               buf_low,
  output logic               irq
);
  localparam int CW       = $clog2(DEPTH + 1);
  localparam int LOW_MARK = DEPTH / 2;

  logic [DEPTH-1:0]   sr_q, sr_n, sr_ins;
  logic [CW-1:0]      free_q, used, take_req, take, used_rd, used_n;
  logic [BYTE_W-1:0]  rev;
  logic [FIELD_W-1:0] head, mask;
  logic               width_ok, wr_ok, low_n;

  always_comb begin
    case (rd_width)
      WID_W'(1), WID_W'(3), WID_W'(4), WID_W'(5), WID_W'(6): width_ok = 1'b1;
      default: width_ok = 1'b0;
    endcase
  end

  for (genvar i = 0; i < BYTE_W; i++) begin : g_rev
    assign rev[i] = wr_data[BYTE_W-1-i];
  end
  for (genvar i = 0; i < FIELD_W; i++) begin : g_head
    assign head[i] = sr_q[DEPTH-1-i];
  end

  assign used     = CW'(DEPTH) - free_q;
  assign take_req = (rd_req && width_ok) ? CW'(rd_width) : '0;
  assign take     = (take_req > used) ? used : take_req;
  assign used_rd  = used - take;
  assign wr_ok    = wr_en && ((CW'(DEPTH) - used_rd) >= CW'(BYTE_W));
  assign used_n   = used_rd + (wr_ok ? CW'(BYTE_W) : '0);
  assign low_n    = used_n < CW'(LOW_MARK);
  assign mask     = ~({FIELD_W{1'b1}} << rd_width);
  assign sr_ins   = wr_ok ? ({rev, {(DEPTH-BYTE_W){1'b0}}} >> used_rd) : '0;
  assign sr_n     = (sr_q << take) | sr_ins;

  assign buf_empty = free_q == CW'(DEPTH);
  assign buf_low   = used < CW'(LOW_MARK);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q        <= '0;
      free_q      <= CW'(DEPTH);
      rd_data     <= '0;
      rd_valid    <= 1'b0;
      rd_underrun <= 1'b0;
      irq         <= 1'b0;
    end else begin
      sr_q        <= sr_n;
      free_q      <= CW'(DEPTH) - used_n;
      rd_valid    <= rd_req && width_ok;
      rd_underrun <= rd_req && width_ok && (take_req > used);
      if (rd_req && width_ok) rd_data <= head & mask;
      if (low_n && !buf_low) irq <= 1'b1;
      else if (stat_rd)      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/field_bitbuf_chk.sv
module field_bitbuf_chk #(
  parameter int DEPTH  = 128,
  parameter int BYTE_W = 8,
  parameter int WID_W  = 3,
  parameter int CW     = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_req,
  input logic [WID_W-1:0] rd_width,
  input logic             stat_rd,
  input logic             rd_valid,
  input logic             rd_underrun,
  input logic             buf_empty,
  input logic             buf_low,
  input logic             irq,
  input logic [CW-1:0]    free_q
);
  logic legal;
  assign legal = (rd_width == WID_W'(1)) || (rd_width == WID_W'(3)) || (rd_width == WID_W'(4)) ||
                 (rd_width == WID_W'(5)) || (rd_width == WID_W'(6));

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (buf_empty && buf_low && !irq && !rd_valid)); // R1
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (rst) free_q <= CW'(DEPTH)); // R3
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst) (rd_req && legal) |=> rd_valid); // R3
  AST_BAD_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !legal && !wr_en) |=> (!rd_valid && $stable(free_q))); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(rd_req && legal) && free_q < CW'(BYTE_W)) |=> $stable(free_q)); // R5
  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_req && free_q >= CW'(BYTE_W)) |=> (free_q == $past(free_q) - CW'(BYTE_W))); // R5
  AST_UNDERRUN_DRAINS: assert property (@(posedge clk) disable iff (rst)
    (rd_req && legal && !wr_en && (CW'(DEPTH) - free_q) < CW'(rd_width)) |=> (buf_empty && rd_underrun)); // R6
  AST_EMPTY_IS_LOW: assert property (@(posedge clk) disable iff (rst) buf_empty |-> buf_low); // R8
  AST_IRQ_ON_LOW: assert property (@(posedge clk) disable iff (rst) $rose(irq) |-> $rose(buf_low)); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst) (irq && !stat_rd) |=> irq); // R9
endmodule

bind field_bitbuf field_bitbuf_chk #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .WID_W(WID_W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_req(rd_req), .rd_width(rd_width), .stat_rd(stat_rd),
  .rd_valid(rd_valid), .rd_underrun(rd_underrun), .buf_empty(buf_empty), .buf_low(buf_low),
  .irq(irq), .free_q(free_q)
);

// File: tb/field_bitbuf_bench.sv
module field_bitbuf_bench;
  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_req = 1'b0, stat_rd = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_width = '0;
  logic [5:0] rd_data;
  logic rd_valid, rd_underrun, buf_empty, buf_low, irq;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  field_bitbuf u_field_bitbuf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_req(rd_req), .rd_width(rd_width),
    .stat_rd(stat_rd), .rd_data(rd_data), .rd_valid(rd_valid), .rd_underrun(rd_underrun),
    .buf_empty(buf_empty), .buf_low(buf_low), .irq(irq)
  );

  // {wr_en, wr_data, rd_req, rd_width, exp_valid, exp_data, exp_underrun, exp_empty, exp_low}
  localparam int NV = 18;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 8'hA5, 1'b0, 3'd0, 1'b0, 6'h00, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 3'd1, 1'b1, 6'h01, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 3'd3, 1'b1, 6'h02, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 3'd4, 1'b1, 6'h0A, 1'b0, 1'b1, 1'b1},
    {1'b1, 8'h3C, 1'b1, 3'd5, 1'b1, 6'h00, 1'b1, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 3'd6, 1'b1, 6'h3C, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 3'd5, 1'b1, 6'h00, 1'b1, 1'b1, 1'b1},
    {1'b1, 8'hFF, 1'b0, 3'd0, 1'b0, 6'h00, 1'b0, 1'b0, 1'b1},
    {1'b1, 8'h01, 1'b0, 3'd0, 1'b0, 6'h00, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 3'd6, 1'b1, 6'h3F, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 3'd6, 1'b1, 6'h07, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 3'd4, 1'b1, 6'h00, 1'b0, 1'b1, 1'b1},
    {1'b1, 8'h81, 1'b0, 3'd0, 1'b0, 6'h00, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 3'd2, 1'b0, 6'h00, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 3'd7, 1'b0, 6'h00, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 3'd1, 1'b1, 6'h01, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 3'd6, 1'b1, 6'h00, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b1, 3'd1, 1'b1, 6'h01, 1'b0, 1'b1, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input bit we, input logic [7:0] wd, input bit rq, input logic [2:0] rw);
    wr_en = we; wr_data = wd; rd_req = rq; rd_width = rw;
    @(negedge clk);
    wr_en = 1'b0; rd_req = 1'b0; rd_width = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic fill16();
    for (int i = 0; i < 16; i++) op(1'b1, 8'(8'h5A ^ (i * 37)), 1'b0, 3'd0);
  endtask

  task automatic drain_count(output int n);
    n = 0;
    for (int k = 0; k < 140; k++) begin
      op(1'b0, 8'h00, 1'b1, 3'd1);
      if (rd_underrun) break;
      n++;
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    int n;
    logic [7:0] b;
    @(negedge clk);
    do_reset();
    check(buf_empty === 1'b1, "R1 R7 empty after reset", int'(buf_empty), 1);
    check(buf_low === 1'b1, "R1 R8 low after reset", int'(buf_low), 1);
    check(irq === 1'b0 && rd_valid === 1'b0, "R1 irq/valid after reset", int'({irq, rd_valid}), 0);

    for (int v = 0; v < NV; v++) begin
      op(VEC[v][22], VEC[v][21:14], VEC[v][13], VEC[v][12:10]);
      check(rd_valid === VEC[v][9], $sformatf("R3 R4 valid vec %0d", v), int'(rd_valid), int'(VEC[v][9]));
      if (VEC[v][9]) begin
        check(rd_data === VEC[v][8:3], $sformatf("R2 R6 data vec %0d", v), int'(rd_data), int'(VEC[v][8:3]));
        check(rd_underrun === VEC[v][2], $sformatf("R6 underrun vec %0d", v), int'(rd_underrun), int'(VEC[v][2]));
      end
      check(buf_empty === VEC[v][1], $sformatf("R7 empty vec %0d", v), int'(buf_empty), int'(VEC[v][1]));
      check(buf_low === VEC[v][0], $sformatf("R8 low vec %0d", v), int'(buf_low), int'(VEC[v][0]));
      check(irq === 1'b0, $sformatf("R9 no irq vec %0d", v), int'(irq), 0);
    end

    // R5: full buffer drops an extra byte; R2 order over many bytes; R8/R9 low and irq on drain
    do_reset();
    fill16();
    check(buf_low === 1'b0 && buf_empty === 1'b0, "R8 R7 flags when full", int'({buf_low, buf_empty}), 0);
    op(1'b1, 8'hFF, 1'b0, 3'd0);
    for (int k = 0; k < 128; k++) begin
      b = 8'(8'h5A ^ ((k / 8) * 37));
      op(1'b0, 8'h00, 1'b1, 3'd1);
      check(rd_data === {5'b0, b[k % 8]}, $sformatf("R2 bit %0d", k), int'(rd_data), int'(b[k % 8]));
      check(buf_low === ((127 - k) < 64), $sformatf("R8 low at %0d", k), int'(buf_low), int'((127 - k) < 64));
      check(irq === ((127 - k) < 64), $sformatf("R9 irq at %0d", k), int'(irq), int'((127 - k) < 64));
    end
    op(1'b0, 8'h00, 1'b1, 3'd1);
    check(rd_underrun === 1'b1 && rd_data === 6'd0, "R5 R6 dropped byte absent", int'(rd_data), 0);
    check(irq === 1'b1, "R9 irq holds", int'(irq), 1);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    check(irq === 1'b0, "R9 irq cleared by status read", int'(irq), 0);
    @(negedge clk);
    check(irq === 1'b0, "R9 irq stays clear", int'(irq), 0);

    // R10: read and write in one cycle, read first
    do_reset();
    fill16();
    op(1'b0, 8'h00, 1'b1, 3'd4);
    op(1'b1, 8'hC3, 1'b1, 3'd4);
    drain_count(n);
    check(n == 128, "R10 read-then-write accepted", n, 128);

    // R5: simultaneous read too small to make room
    do_reset();
    fill16();
    op(1'b1, 8'hC3, 1'b1, 3'd6);
    drain_count(n);
    check(n == 122, "R5 write rejected after small read", n, 122);

    // R4: illegal width leaves contents untouched
    do_reset();
    op(1'b1, 8'hFF, 1'b0, 3'd0);
    op(1'b0, 8'h00, 1'b1, 3'd0);
    check(rd_valid === 1'b0, "R4 width 0 ignored", int'(rd_valid), 0);
    drain_count(n);
    check(n == 8, "R4 contents unchanged", n, 8);

    finish_run();
  end
endmodule